// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller

The block collects 32 level-sensitive interrupt lines and presents them to a processor as two interrupt outputs. Each line is sampled into a raw register. It passes to an output only when its bit in an enable mask is set, and its bit in a type register picks which of the two outputs it drives. Bit 31 of the enable mask has a second job as a master switch over both outputs. Software changes the mask through two write-only-effect addresses: one sets the bits written as 1 and the other clears them. No read-modify-write sequence is needed.

Software reads raw levels and per-output masked views through single-cycle register reads. A helper output gives the index of the lowest-numbered source pending on output 0, so a handler can dispatch without scanning. A status bit follows its line directly. Nothing is latched, and a source is serviced by removing its level at the device that drives it.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset the enable mask (global bit included) and the type register read as zero, both CPU outputs are low and the pending flag is low.
- R2: A write to offset 0x34 sets every mask bit whose data bit is 1 and leaves all other mask bits unchanged.
- R3: A write to offset 0x38 clears every mask bit whose data bit is 1 and leaves all other mask bits unchanged; reads of either 0x34 or 0x38 return the current mask.
- R4: Offset 0x20 is a read/write type register; type bit n = 0 routes source n to output 0, type bit n = 1 routes it to output 1.
- R5: Offset 0x30 returns the input levels as sampled on the previous rising clock edge, with no masking.
- R6: Offset 0x00 returns raw AND mask AND NOT type, and offset 0x04 returns raw AND mask AND type; a bit drops as soon as its sampled level drops, with no clearing write.
- R7: While mask bit 31 is 0, neither CPU output is high, whatever the other mask bits are.
- R8: cpu_irq0_o is high exactly when the 0x00 view is nonzero and mask bit 31 is 1, and cpu_irq1_o likewise for the 0x04 view; an input change reaches the outputs after the next rising clock edge.
- R9: Writes to 0x00, 0x04 and 0x30 change no state; reads of any offset other than 0x00, 0x04, 0x20, 0x30, 0x34, 0x38 return zero.
- R10: pend_idx_o gives the lowest bit number set in the 0x00 view and pend_valid_o is 1; when that view is zero, pend_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 32 | Level interrupt lines, active high |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 8 | Byte offset of the register accessed |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| cpu_irq0_o | output | 1 | CPU interrupt output 0 |
| cpu_irq1_o | output | 1 | CPU interrupt output 1 |
| pend_idx_o | output | 5 | Lowest pending source number on output 0 |
| pend_valid_o | output | 1 | pend_idx_o is meaningful |

## Verification
On every cycle the assertions check that the set and clear writes touch only the selected mask bits, that writes to read-only offsets leave the state unchanged, and that the two status views never share a bit. They also check that the master bit silences both outputs and that the helper index always points at the lowest pending bit. Only the bench's scenarios can show the values: the register contents against a model and the one-edge latency from an input change. They also cover the level-following behaviour when a line drops and the zero returned for unmapped offsets, under random mixes of writes and input patterns.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned NUM_OUT = 2;
  localparam int unsigned OFS_ST0   = 'h00;
  localparam int unsigned OFS_ST1   = 'h04;
  localparam int unsigned OFS_TYPE  = 'h20;
  localparam int unsigned OFS_RAW   = 'h30;
  localparam int unsigned OFS_ENSET = 'h34;
  localparam int unsigned OFS_ENCLR = 'h38;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] raw_i,
  input  logic [NUM_SRC-1:0] st0_i,
  input  logic [NUM_SRC-1:0] st1_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] type_o,
  output logic [NUM_SRC-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_ST0   = ADDR_W'(OFS_ST0);
  localparam logic [ADDR_W-1:0] A_ST1   = ADDR_W'(OFS_ST1);
  localparam logic [ADDR_W-1:0] A_TYPE  = ADDR_W'(OFS_TYPE);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(OFS_ENSET);
  localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(OFS_ENCLR);

  logic [NUM_SRC-1:0] mask_q, type_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      type_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_ENSET: mask_q <= mask_q | wdata_i;
        A_ENCLR: mask_q <= mask_q & ~wdata_i;
        A_TYPE:  type_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      A_ST0:            rdata_o = st0_i;
      A_ST1:            rdata_o = st1_i;
      A_TYPE:           rdata_o = type_q;
      A_RAW:            rdata_o = raw_i;
      A_ENSET, A_ENCLR: rdata_o = mask_q;
      default:          rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;
  assign type_o = type_q;

  AST_SET_HITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_ENSET) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i))); // R2
  AST_SET_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_ENSET) |=> ((mask_q & $past(mask_q)) == $past(mask_q))); // R2
  AST_CLR_HITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_ENCLR) |=> ((mask_q & $past(wdata_i)) == '0)); // R3
  AST_CLR_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_ENCLR) |=>
      ((mask_q & ~$past(wdata_i)) == ($past(mask_q) & ~$past(wdata_i)))); // R3
  AST_RO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == A_ST0 || addr_i == A_ST1 || addr_i == A_RAW))
      |=> ($stable(mask_q) && $stable(type_q))); // R9
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [NUM_SRC-1:0] type_i,
  output logic [NUM_SRC-1:0] raw_o,
  output logic [NUM_SRC-1:0] st0_o,
  output logic [NUM_SRC-1:0] st1_o,
  output logic [NUM_OUT-1:0] cpu_o
);
  localparam int unsigned GLB = NUM_SRC - 1;

  logic [NUM_SRC-1:0] raw_q;
  logic [NUM_SRC-1:0] st [NUM_OUT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= irq_i;
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    // type bit equal to k selects output k
    logic [NUM_SRC-1:0] sel;
    assign sel      = (k == 0) ? ~type_i : type_i;
    assign st[k]    = raw_q & mask_i & sel;
    assign cpu_o[k] = (|st[k]) & mask_i[GLB];
  end

  assign raw_o = raw_q;
  assign st0_o = st[0];
  assign st1_o = st[1];

  AST_VIEWS_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st0_o & st1_o) == '0); // R6
  AST_VIEWS_COVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st0_o | st1_o) == (raw_q & mask_i)); // R6
endmodule

// File: rtl/irq_lowest.sv
module irq_lowest #(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] vec_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               valid_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |vec_i;

  logic [NUM_SRC-1:0] below;
  assign below = vec_i & ((NUM_SRC'(1) << idx_o) - NUM_SRC'(1));

  AST_IDX_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> vec_i[idx_o]); // R10
  AST_IDX_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (below == '0)); // R10
  AST_IDX_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (vec_i == '0)); // R10
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               cpu_irq0_o,
  output logic               cpu_irq1_o,
  output logic [IDX_W-1:0]   pend_idx_o,
  output logic               pend_valid_o
);
  localparam int unsigned GLB = NUM_SRC - 1;

  logic [NUM_SRC-1:0] mask, typ, raw, st0, st1;
  logic [NUM_OUT-1:0] cpu;

  irq_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .raw_i(raw), .st0_i(st0), .st1_i(st1),
    .mask_o(mask), .type_o(typ), .rdata_o
  );

  irq_route #(.NUM_SRC(NUM_SRC)) u_route (
    .clk_i, .rst_ni, .irq_i, .mask_i(mask), .type_i(typ),
    .raw_o(raw), .st0_o(st0), .st1_o(st1), .cpu_o(cpu)
  );

  irq_lowest #(.NUM_SRC(NUM_SRC)) u_lowest (
    .clk_i, .rst_ni, .vec_i(st0), .idx_o(pend_idx_o), .valid_o(pend_valid_o)
  );

  assign cpu_irq0_o = cpu[0];
  assign cpu_irq1_o = cpu[1];

  AST_GLOBAL_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask[GLB] |-> (!cpu_irq0_o && !cpu_irq1_o)); // R7
  AST_OUT0_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_irq0_o |-> pend_valid_o); // R8
endmodule

// File: tb/irq_level_ctrl_tb.sv
`timescale 1ns/100ps
module irq_level_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] irq = '0;
  logic        wr_en = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cpu0, cpu1, pvalid;
  logic [4:0]  pidx;

  int checks = 0, errors = 0;
  logic [31:0] m_mask = '0, m_type = '0, m_raw = '0;

  always #2 clk = ~clk;

  irq_level_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cpu_irq0_o(cpu0), .cpu_irq1_o(cpu1),
    .pend_idx_o(pidx), .pend_valid_o(pvalid)
  );

  function automatic logic [31:0] f_st0();
    return m_raw & m_mask & ~m_type;
  endfunction
  function automatic logic [31:0] f_st1();
    return m_raw & m_mask & m_type;
  endfunction
  function automatic logic [5:0] f_low(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return {1'b1, 5'(i)};
    return 6'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #0.2;
    chk(tag, rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk);
    case (a)
      8'h34: m_mask = m_mask | d;
      8'h38: m_mask = m_mask & ~d;
      8'h20: m_type = d;
      default: ;
    endcase
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk);
    irq = v;
    @(posedge clk);
    m_raw = v;
    @(negedge clk);
  endtask

  task automatic check_all();
    logic [5:0] lo;
    lo = f_low(f_st0());
    rd(8'h34, m_mask, "R2 mask via set offset");
    rd(8'h38, m_mask, "R3 mask via clear offset");
    rd(8'h20, m_type, "R4 type");
    rd(8'h30, m_raw, "R5 raw");
    rd(8'h00, f_st0(), "R6 status0");
    rd(8'h04, f_st1(), "R6 status1");
    chk("R8 cpu0", {31'd0, cpu0}, {31'd0, (f_st0() != 0) && m_mask[31]});
    chk("R8 cpu1", {31'd0, cpu1}, {31'd0, (f_st1() != 0) && m_mask[31]});
    chk("R10 valid", {31'd0, pvalid}, {31'd0, lo[5]});
    if (lo[5]) chk("R10 index", {27'd0, pidx}, {27'd0, lo[4:0]});
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    #9 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h34, 32'h0, "R1 mask after reset");
    rd(8'h20, 32'h0, "R1 type after reset");
    chk("R1 outputs low", {30'd0, cpu0, cpu1}, 32'd0);
    chk("R1 pend flag low", {31'd0, pvalid}, 32'd0);

    // R7: sources enabled and pending, global off
    drive(32'h0000_00F0);
    wr(8'h34, 32'h7FFF_FFFF);
    check_all();
    chk("R7 outputs off with global clear", {30'd0, cpu0, cpu1}, 32'd0);

    // R8 latency: enable global, then input change seen after one edge
    wr(8'h34, 32'h8000_0000);
    check_all();
    drive(32'h0);
    check_all();
    @(negedge clk);
    irq = 32'h0000_0400;
    #1 chk("R8 before edge", {31'd0, cpu0}, 32'd0);
    @(posedge clk); m_raw = irq;
    #1 chk("R8 after edge", {31'd0, cpu0}, 32'd1);
    chk("R10 index bit 10", {27'd0, pidx}, 32'd10);
    @(negedge clk);

    // R6 level follow: drop the line, status clears without any write
    drive(32'h0);
    rd(8'h00, 32'h0, "R6 status drops with level");
    chk("R6 cpu0 drops", {31'd0, cpu0}, 32'd0);

    // R4 route all to output 1
    wr(8'h20, 32'hFFFF_FFFF);
    drive(32'h0000_0101);
    check_all();
    chk("R4 only output1", {30'd0, cpu0, cpu1}, 32'd1);
    chk("R10 no pend on output0", {31'd0, pvalid}, 32'd0);
    wr(8'h20, 32'h0);

    // R10 bit 31 alone
    drive(32'h8000_0000);
    check_all();
    chk("R10 index bit 31", {27'd0, pidx}, 32'd31);

    // R3 clear subset, R9 ignored writes and unmapped reads
    wr(8'h38, 32'h0000_FF00);
    check_all();
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h30, 32'h1234_5678);
    check_all();
    rd(8'h10, 32'h0, "R9 unmapped 0x10");
    rd(8'h3C, 32'h0, "R9 unmapped 0x3C");
    rd(8'h24, 32'h0, "R9 unmapped 0x24");
    // R3 clear all ones disables everything
    wr(8'h38, 32'hFFFF_FFFF);
    check_all();
    chk("R3 all cleared", {30'd0, cpu0, cpu1}, 32'd0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [31:0] v;
      op = $urandom_range(0, 5);
      v = $urandom();
      if ($urandom_range(0, 3) == 0) v = v & $urandom() & $urandom();
      case (op)
        0: drive(v);
        1: wr(8'h34, v);
        2: wr(8'h38, v);
        3: wr(8'h20, v);
        4: wr(($urandom_range(0, 1) == 0) ? 8'h00 : 8'h30, v);
        default: wr(8'h34, 32'h8000_0000);
      endcase
      check_all();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule